// File: doc/BRIEF.md
# PS/2 Host Port Register Front End

This block is the processor-facing register bank of a PS/2 keyboard or mouse port. Software reaches it through a 4 KB window of 32-bit words, with a single-cycle read strobe and a single-cycle write strobe. Read data is combinational in the cycle of the strobe. On the device side it talks in whole bytes. A one-cycle `rx_valid` pulse delivers a received byte, and a one-cycle `tx_valid` pulse hands a byte to the serialiser for transmission. Bit-level line timing and device command handling live behind that byte interface. The sampled states of the two PS/2 lines come back in for the status register.

A received byte waits in a holding register and raises a pending flag. A data-register read moves the byte into the "last byte" register and clears the flag. Status parity is computed over that last byte. The transmit side always reports empty. The level interrupt combines the pending flag with two control bits. Identification bytes fill the top eight words of the window. Accesses that decode to nothing set a sticky error flag. A byte that arrives while one is already pending sets a sticky overrun flag.

Top module: `ps2_host_regs`

## Requirements
- R1: After reset, control, divisor, last byte and pending are all 0. `irq`, `tx_valid`, `bad_access` and `rx_overrun` are low. The line-state bits read 1 until the first sampled value arrives.
- R2: Control (word 0, 8 bits, upper bits read 0) and clock divisor (word 3, 32 bits) store the written value and read it back unchanged.
- R3: `irq` is high exactly when (pending AND control bit 4) OR control bit 3. It follows a control write or a pending change from the next cycle on.
- R4: An `rx_valid` pulse while nothing is pending stores `rx_data` and sets pending. Pending reads as bit 4 of status (word 1) and as bit 0 of interrupt status (word 4).
- R5: A read of data (word 2) while pending returns the held byte in the same cycle. That byte becomes the last byte, and pending clears on the next cycle. A read while not pending returns the last byte and changes nothing.
- R6: An `rx_valid` pulse while pending drops its byte (the held byte is kept) and sets `rx_overrun`, which stays set until reset. This includes the cycle of a consuming read.
- R7: Status bit 6 reads 1, bits 5 and 3 read 0, and bit 2 is the XOR of the 8 bits of the last byte.
- R8: Status bit 1 reflects `line_clk` and bit 0 reflects `line_dat`, each after SYNC_STAGES register stages.
- R9: Interrupt status reads pending in bit 0 and a constant 1 in bit 1, with all other bits 0.
- R10: Reads of words 0x3F8 to 0x3FF return, in order, 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: A write to data (word 2) drives `tx_valid` high in the following cycle for exactly one cycle, with `tx_data` equal to write bits [7:0].
- R12: A read of any word from 5 to 0x3F7 returns 0. A write to any word other than 0, 2 or 3 changes no register. Either access sets `bad_access`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | Word index into the 4 KB window (byte address bits 11:2) |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle, 0 when no read |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Byte to transmit |
| line_clk | input | 1 | Sampled PS/2 clock line |
| line_dat | input | 1 | Sampled PS/2 data line |
| bad_access | output | 1 | Sticky flag for an access that decodes to nothing |
| rx_overrun | output | 1 | Sticky flag for a dropped received byte |

## Verification
Read data is due in the strobe cycle itself, so the bench samples `bus_rdata` one time step after driving the strobe on a falling edge, before the next rising edge. Every state change (pending, last byte, control, `irq`, `tx_valid`, the sticky flags) is due one rising edge after the stimulus, so the bench samples those on the next falling edge. The absence of `tx_valid` is checked one falling edge later still. Line states are due SYNC_STAGES rising edges after the line changes, and the bench waits exactly two falling edges before reading status.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;

   // word offsets inside the window
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_STAT = 1;
   localparam int unsigned OFS_DATA = 2;
   localparam int unsigned OFS_DIV  = 3;
   localparam int unsigned OFS_ISR  = 4;

   // status bit positions
   localparam int unsigned ST_TX_EMPTY = 6;
   localparam int unsigned ST_TX_BUSY  = 5;
   localparam int unsigned ST_RX_FULL  = 4;
   localparam int unsigned ST_RX_BUSY  = 3;
   localparam int unsigned ST_RX_PAR   = 2;
   localparam int unsigned ST_LINE_CLK = 1;
   localparam int unsigned ST_LINE_DAT = 0;

   // control bits that feed the interrupt
   localparam int unsigned CR_FORCE_IRQ = 3;
   localparam int unsigned CR_RX_IRQ_EN = 4;

   // interrupt status bits
   localparam int unsigned IS_RX = 0;
   localparam int unsigned IS_TX = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_STAT,
      SEL_DATA,
      SEL_DIV,
      SEL_ISR,
      SEL_ID
   } reg_sel_e;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0:    id_byte = 8'h50;
         3'd1:    id_byte = 8'h10;
         3'd2:    id_byte = 8'h04;
         3'd3:    id_byte = 8'h00;
         3'd4:    id_byte = 8'h0D;
         3'd5:    id_byte = 8'hF0;
         3'd6:    id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction

endpackage

// File: rtl/ps2_addr_decode.sv
module ps2_addr_decode
   import ps2_host_pkg::*;
#(
   parameter int unsigned WORD_W = 10
) (
   input  logic [WORD_W-1:0] word,
   input  logic              rd,
   input  logic              wr,
   output reg_sel_e          sel,
   output logic [2:0]        id_idx,
   output logic              bad_hit
);

   localparam int unsigned    WORDS    = 1 << WORD_W;
   localparam logic [WORD_W-1:0] ID_FIRST = WORD_W'(WORDS - 8);

   always_comb begin
      sel = SEL_NONE;
      if (word >= ID_FIRST) begin
         sel = SEL_ID;
      end else begin
         case (word)
            WORD_W'(OFS_CTRL): sel = SEL_CTRL;
            WORD_W'(OFS_STAT): sel = SEL_STAT;
            WORD_W'(OFS_DATA): sel = SEL_DATA;
            WORD_W'(OFS_DIV):  sel = SEL_DIV;
            WORD_W'(OFS_ISR):  sel = SEL_ISR;
            default:           sel = SEL_NONE;
         endcase
      end
   end

   assign id_idx = word[2:0];

   // unmapped reads, and writes to anything but the three writable words
   always_comb begin
      bad_hit = 1'b0;
      if (rd && (sel == SEL_NONE)) bad_hit = 1'b1;
      if (wr && !((sel == SEL_CTRL) || (sel == SEL_DATA) || (sel == SEL_DIV)))
         bad_hit = 1'b1;
   end

endmodule

// File: rtl/ps2_rx_hold.sv
module ps2_rx_hold #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              consume,
   output logic              pending,
   output logic [BYTE_W-1:0] hold_byte,
   output logic [BYTE_W-1:0] last_byte,
   output logic              overrun
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         hold_byte <= '0;
         last_byte <= '0;
         overrun   <= 1'b0;
      end else begin
         if (rx_valid) begin
            if (pending) begin
               overrun <= 1'b1;
            end else begin
               hold_byte <= rx_data;
               pending   <= 1'b1;
            end
         end
         if (consume && pending) begin
            last_byte <= hold_byte;
            pending   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_flops
         logic [STAGES*LINES-1:0] chain_q;
         if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= '1;
               else        chain_q <= din;
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= '1;
               else        chain_q <= {chain_q[(STAGES-1)*LINES-1:0], din};
            end
         end
         assign dout = chain_q[STAGES*LINES-1 -: LINES];
      end
   endgenerate

endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
   import ps2_host_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CTRL_W      = 8,
   parameter int unsigned DIV_W       = 32,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:2] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              line_clk,
   input  logic              line_dat,
   output logic              bad_access,
   output logic              rx_overrun
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   generate
      if (ADDR_W < 6) begin : g_chk_addr
         $error("ADDR_W too small for the identification words");
      end
      if (DATA_W < 8) begin : g_chk_data
         $error("DATA_W must hold a status byte");
      end
      if ((CTRL_W <= CR_RX_IRQ_EN) || (CTRL_W > DATA_W)) begin : g_chk_ctrl
         $error("CTRL_W must cover the interrupt bits and fit the bus");
      end
      if ((DIV_W == 0) || (DIV_W > DATA_W)) begin : g_chk_div
         $error("DIV_W out of range");
      end
      if ((BYTE_W == 0) || (BYTE_W > DATA_W)) begin : g_chk_byte
         $error("BYTE_W out of range");
      end
   endgenerate

   reg_sel_e          sel;
   logic [2:0]        id_idx;
   logic              bad_hit;
   logic              pending;
   logic [BYTE_W-1:0] hold_byte;
   logic [BYTE_W-1:0] last_byte;
   logic [1:0]        line_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DIV_W-1:0]  div_q;
   logic              tx_valid_q;
   logic [BYTE_W-1:0] tx_data_q;
   logic              bad_q;
   logic              consume;

   ps2_addr_decode #(.WORD_W(WORD_W)) u_decode (
      .word    (bus_addr),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .sel     (sel),
      .id_idx  (id_idx),
      .bad_hit (bad_hit)
   );

   assign consume = bus_rd && (sel == SEL_DATA);

   ps2_rx_hold #(.BYTE_W(BYTE_W)) u_rx_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .consume   (consume),
      .pending   (pending),
      .hold_byte (hold_byte),
      .last_byte (last_byte),
      .overrun   (rx_overrun)
   );

   ps2_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_line_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({line_clk, line_dat}),
      .dout  (line_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         div_q      <= '0;
         tx_valid_q <= 1'b0;
         tx_data_q  <= '0;
         bad_q      <= 1'b0;
      end else begin
         tx_valid_q <= 1'b0;
         if (bus_wr && (sel == SEL_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (bus_wr && (sel == SEL_DIV))  div_q  <= bus_wdata[DIV_W-1:0];
         if (bus_wr && (sel == SEL_DATA)) begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= bus_wdata[BYTE_W-1:0];
         end
         if (bad_hit) bad_q <= 1'b1;
      end
   end

   assign tx_valid   = tx_valid_q;
   assign tx_data    = tx_data_q;
   assign bad_access = bad_q;
   assign irq        = (pending && ctrl_q[CR_RX_IRQ_EN]) || ctrl_q[CR_FORCE_IRQ];

   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] isr_word;

   always_comb begin
      stat_word              = '0;
      stat_word[ST_TX_EMPTY] = 1'b1;
      stat_word[ST_TX_BUSY]  = 1'b0;
      stat_word[ST_RX_FULL]  = pending;
      stat_word[ST_RX_BUSY]  = 1'b0;
      stat_word[ST_RX_PAR]   = ^last_byte;
      stat_word[ST_LINE_CLK] = line_q[1];
      stat_word[ST_LINE_DAT] = line_q[0];
      isr_word               = '0;
      isr_word[IS_RX]        = pending;
      isr_word[IS_TX]        = 1'b1;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_CTRL: bus_rdata = DATA_W'(ctrl_q);
            SEL_STAT: bus_rdata = stat_word;
            SEL_DATA: bus_rdata = DATA_W'(pending ? hold_byte : last_byte);
            SEL_DIV:  bus_rdata = DATA_W'(div_q);
            SEL_ISR:  bus_rdata = isr_word;
            SEL_ID:   bus_rdata = DATA_W'(id_byte(id_idx));
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/ps2_host_regs_chk.sv
module ps2_host_regs_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:2] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              tx_valid,
   input logic              bad_access,
   input logic              rx_overrun
);

   localparam int unsigned       WORD_W   = ADDR_W - 2;
   localparam logic [WORD_W-1:0] ID_FIRST = WORD_W'((1 << WORD_W) - 8);
   localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(0);
   localparam logic [WORD_W-1:0] W_DATA   = WORD_W'(2);
   localparam logic [WORD_W-1:0] W_FIRST_HOLE = WORD_W'(5);

   // R3
   irq_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == W_CTRL) && bus_rdata[3]) |-> irq);

   // R3
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == W_CTRL) && (bus_rdata == '0)) |-> !irq);

   // R10
   id_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ID_FIRST)) |-> (bus_rdata == DATA_W'(8'h50)));

   // R12
   hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr >= W_FIRST_HOLE) && (bus_addr < ID_FIRST))
      |-> (bus_rdata == '0));

   // R12
   bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |=> bad_access);

   // R6
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |=> rx_overrun);

   // R11
   tx_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == W_DATA)) |=> tx_valid);

   // R11
   tx_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_wr && (bus_addr == W_DATA)));

endmodule

bind ps2_host_regs ps2_host_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ps2_host_regs_bench.sv
`timescale 1ns/1ps
module ps2_host_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:2] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        line_clk = 1'b1;
   logic        line_dat = 1'b1;
   logic        bad_access;
   logic        rx_overrun;

   always #2.5 clk = ~clk;

   ps2_host_regs u_ps2_host_regs (
      .clk, .rst_n, .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata,
      .irq, .rx_valid, .rx_data, .tx_valid, .tx_data,
      .line_clk, .line_dat, .bad_access, .rx_overrun
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state
   logic [7:0]  m_ctrl = '0;
   logic [31:0] m_div  = '0;
   logic [7:0]  m_last = '0;
   logic [7:0]  m_hold = '0;
   logic        m_pend = 1'b0;
   logic        m_ovr  = 1'b0;
   logic        m_bad  = 1'b0;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic exp_irq();
      return (m_pend && m_ctrl[4]) || m_ctrl[3];
   endfunction

   function automatic logic [31:0] exp_stat();
      logic [31:0] v = 32'h40;
      v[4] = m_pend;
      v[2] = ^m_last;
      v[1] = line_clk;
      v[0] = line_dat;
      return v;
   endfunction

   function automatic logic [7:0] exp_id(input int i);
      case (i)
         0: return 8'h50;  1: return 8'h10;  2: return 8'h04;  3: return 8'h00;
         4: return 8'h0D;  5: return 8'hF0;  6: return 8'h05;  default: return 8'hB1;
      endcase
   endfunction

   task automatic bus_read(input logic [9:0] w, output logic [31:0] v);
      @(negedge clk);
      bus_addr = w; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [9:0] w, input logic [31:0] d);
      @(negedge clk);
      bus_addr = w; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic inject(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
      if (m_pend) m_ovr = 1'b1;
      else begin m_hold = b; m_pend = 1'b1; end
   endtask

   task automatic read_data_chk();
      logic [31:0] v;
      bus_read(10'd2, v);
      chk("R5 data read", v, {24'h0, m_pend ? m_hold : m_last});
      if (m_pend) begin m_last = m_hold; m_pend = 1'b0; end
   endtask

   task automatic side_chk();
      chk("R3 irq", {31'h0, irq}, {31'h0, exp_irq()});
      chk("R6 overrun flag", {31'h0, rx_overrun}, {31'h0, m_ovr});
      chk("R12 bad flag", {31'h0, bad_access}, {31'h0, m_bad});
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] d;
      logic [9:0]  w;
      void'($urandom(32'h0005EED1));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'h0, irq}, 32'h0);
      chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
      chk("R1 flags", {30'h0, bad_access, rx_overrun}, 32'h0);
      bus_read(10'd0, v); chk("R1 control", v, 32'h0);
      bus_read(10'd3, v); chk("R1 divisor", v, 32'h0);
      bus_read(10'd1, v); chk("R1 status", v, 32'h43);
      bus_read(10'd4, v); chk("R9 isr idle", v, 32'h2);
      bus_read(10'd2, v); chk("R1 data", v, 32'h0);

      // R10 identification words
      for (int i = 0; i < 8; i++) begin
         bus_read(10'(10'h3F8 + i), v);
         chk("R10 id byte", v, {24'h0, exp_id(i)});
      end

      // R8 line states, two stages
      @(negedge clk); line_clk = 1'b0; line_dat = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_read(10'd1, v); chk("R8 line clk low", v[1:0], 32'h1);
      @(negedge clk); line_clk = 1'b1; line_dat = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bus_read(10'd1, v); chk("R8 line dat low", v[1:0], 32'h2);
      @(negedge clk); line_dat = 1'b1;
      @(negedge clk);
      @(negedge clk);

      // R4 capture and R7 parity of an odd byte
      bus_write(10'd0, 32'h10); m_ctrl = 8'h10;
      chk("R3 irq idle with enable", {31'h0, irq}, 32'h0);
      inject(8'h07);
      chk("R3 irq on pending", {31'h0, irq}, 32'h1);
      bus_read(10'd1, v); chk("R4 status full", v, exp_stat());
      bus_read(10'd4, v); chk("R4 isr pending", v, 32'h3);
      // R6 overrun keeps the first byte
      inject(8'hAA);
      side_chk();
      read_data_chk();
      chk("R3 irq cleared", {31'h0, irq}, 32'h0);
      bus_read(10'd1, v); chk("R7 parity odd", v, exp_stat());
      read_data_chk();

      // R11 transmit pulse
      bus_write(10'd2, 32'hFFFF_FF3C);
      chk("R11 tx_valid", {31'h0, tx_valid}, 32'h1);
      chk("R11 tx_data", {24'h0, tx_data}, 32'h3C);
      @(negedge clk);
      chk("R11 single pulse", {31'h0, tx_valid}, 32'h0);

      // R12 write to status ignored
      bus_write(10'd1, 32'hFFFF_FFFF); m_bad = 1'b1;
      bus_read(10'd1, v); chk("R12 status unchanged", v, exp_stat());
      side_chk();

      // random mix
      for (int k = 0; k < 600; k++) begin
         case ($urandom % 10)
            0, 1: inject(8'($urandom));
            2, 3: read_data_chk();
            4: begin bus_read(10'd1, v); chk("R7 status", v, exp_stat()); end
            5: begin bus_read(10'd4, v); chk("R9 isr", v, {30'h0, 1'b1, m_pend}); end
            6: begin
               d = $urandom;
               bus_write(10'd0, d); m_ctrl = d[7:0];
               bus_read(10'd0, v); chk("R2 control", v, {24'h0, m_ctrl});
            end
            7: begin
               d = $urandom;
               bus_write(10'd3, d); m_div = d;
               bus_read(10'd3, v); chk("R2 divisor", v, m_div);
            end
            8: begin
               d = $urandom;
               bus_write(10'd2, d);
               chk("R11 tx_valid", {31'h0, tx_valid}, 32'h1);
               chk("R11 tx_data", {24'h0, tx_data}, {24'h0, d[7:0]});
               @(negedge clk);
               chk("R11 single pulse", {31'h0, tx_valid}, 32'h0);
            end
            default: begin
               if ($urandom % 2 == 0) begin
                  w = 10'(5 + ($urandom % 1011));
                  bus_read(w, v); chk("R12 hole read", v, 32'h0);
               end else begin
                  case ($urandom % 3)
                     0: w = 10'd1;
                     1: w = 10'd4;
                     default: w = 10'(5 + ($urandom % 1019));
                  endcase
                  bus_write(w, $urandom);
               end
               m_bad = 1'b1;
            end
         endcase
         side_chk();
      end

      bus_read(10'd0, v); chk("R2 control final", v, {24'h0, m_ctrl});
      bus_read(10'd3, v); chk("R2 divisor final", v, m_div);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule